// File: doc/BRIEF.md
# Branch record filter and compactor

The block post-processes a small buffer of captured branch records. When started, it walks the records from index 0 upward. For each record it asks an external classifier for a type mask. It adds a transaction tag to that mask when the request asks for one, and decides whether the record survives the caller's selection mask. Survivors are written back toward the front of the same buffer in their original order, and a new record count is reported.

An optional mode collapses duplicated abort records before the selection is applied. Instruction decoding is not part of this block: it happens behind a request/acknowledge handshake that can take any number of cycles.

The buffer sits behind a synchronous single-port RAM interface with one cycle of read latency. A record carries a source address, a target address, an abort flag and an in-transaction flag.

Top module: `brf_filter_compact`

## Requirements
- R1: When the selection holds all seven bits 0 to 6, every record is kept without filtering, and no classifier request is issued. The type bits are: bit 0 user, bit 1 kernel, bit 2 call, bit 3 return, bit 4 conditional, bit 5 jump, bit 6 abort, bit 7 in-transaction, bit 8 not-in-transaction.
- R2: When the classified type is non-zero and the selection has bit 7 or bit 8 set, the type gains bit 7 if the record's in-transaction flag is 1, and bit 8 otherwise.
- R3: A record is dropped when its (possibly tagged) type is zero, or when the selection ANDed with the type differs from the type.
- R4: Surviving records occupy slots 0 to count-1 in their original relative order, and the reported count equals the number of survivors.
- R5: When no record is dropped and none is collapsed, the block issues no RAM write.
- R6: With the collapse mode on, an abort record that is not the first in the walk removes the record walked just before it, so the abort record takes that place in the output. An abort record at index 0 removes nothing.
- R7: `done` is high for exactly one cycle per run. `count_out` is valid in that cycle and holds its value until the next run ends.
- R8: A `start` pulse while a run is in progress has no effect on that run's result.
- R9: `cls_req` stays high with unchanged record fields until the cycle in which `cls_ack` is seen.
- R10: After reset, `done`, `cls_req`, `mem_rd` and `mem_we` are low and `count_out` is 0.
- R11: A run with a count of 0 ends with a count of 0 and no RAM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| sel_mask | input | 9 | Requested type selection |
| dedup_en | input | 1 | Enables collapsing of duplicated abort records |
| count_in | input | CNT_W | Number of valid records in the buffer |
| done | output | 1 | One-cycle end-of-run pulse |
| count_out | output | CNT_W | Record count after the run |
| mem_addr | output | IDX_W | RAM address for read or write |
| mem_rd | output | 1 | RAM read strobe, data valid next cycle |
| mem_rdata_from | input | VA_W | Read source address |
| mem_rdata_to | input | VA_W | Read target address |
| mem_rdata_abort | input | 1 | Read abort flag |
| mem_rdata_intx | input | 1 | Read in-transaction flag |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata_from | output | VA_W | Write source address |
| mem_wdata_to | output | VA_W | Write target address |
| mem_wdata_abort | output | 1 | Write abort flag |
| mem_wdata_intx | output | 1 | Write in-transaction flag |
| cls_req | output | 1 | Classification request |
| cls_from | output | VA_W | Source address to classify |
| cls_to | output | VA_W | Target address to classify |
| cls_abort | output | 1 | Abort flag of the record being classified |
| cls_ack | input | 1 | Classification response valid |
| cls_type | input | 9 | Classified type mask |

## Verification
The bench builds the block with DEPTH set to 4 and VA_W set to 12. With only four slots, every record count from 0 to 4 is reachable, and so is every position of a dropped or collapsed record, including an abort at index 0. Across many runs the nine-bit selection is drawn both from structured families (the bypass set, tagged and untagged transaction masks) and at random. The bench classifier returns a type taken from the record's target field, after a latency set by its source field, so handshakes of varying length are exercised.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int unsigned TYPE_W = 9;

    typedef struct packed {
        logic no_tx;
        logic in_tx;
        logic abort;
        logic jump;
        logic cond;
        logic ret;
        logic call;
        logic kernel;
        logic user;
    } brtype_t;

    localparam logic [TYPE_W-1:0] FULL_SEL = 9'h07F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LATCH,
        ST_CLASS,
        ST_DECIDE,
        ST_DONE
    } walk_st_t;

    function automatic logic sel_is_bypass(logic [TYPE_W-1:0] sel);
        return (sel & FULL_SEL) == FULL_SEL;
    endfunction

    function automatic brtype_t tag_tx(brtype_t t, brtype_t sel, logic rec_intx);
        brtype_t r;
        r = t;
        if ((t != '0) && (sel.in_tx || sel.no_tx)) begin
            if (rec_intx) r.in_tx = 1'b1;
            else          r.no_tx = 1'b1;
        end
        return r;
    endfunction

    function automatic logic type_fits(brtype_t t, brtype_t sel);
        logic [TYPE_W-1:0] tv;
        logic [TYPE_W-1:0] sv;
        tv = t;
        sv = sel;
        return (tv != '0) && ((sv & tv) == tv);
    endfunction

endpackage

// File: rtl/brf_judge.sv
module brf_judge
    import brf_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  brtype_t            sel,
    input  brtype_t            typ,
    input  logic               rec_intx,
    input  logic               rec_abort,
    input  logic               bypass,
    input  logic               dedup,
    input  logic               at_first,
    input  logic               prev_kept,
    input  logic [CNT_W-1:0]   wp,
    output logic               keep,
    output logic [CNT_W-1:0]   slot,
    output logic [CNT_W-1:0]   wp_next
);
    logic collapse;

    always_comb begin
        collapse = dedup && rec_abort && !at_first && prev_kept;
        slot     = collapse ? (wp - CNT_W'(1)) : wp;
        keep     = bypass || type_fits(tag_tx(typ, sel, rec_intx), sel);
        wp_next  = slot + CNT_W'(keep);
    end
endmodule

// File: rtl/brf_rec_hold.sv
module brf_rec_hold
    import brf_pkg::*;
#(
    parameter int unsigned VA_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_rec,
    input  logic            cap_typ,
    input  logic [VA_W-1:0] in_from,
    input  logic [VA_W-1:0] in_to,
    input  logic            in_abort,
    input  logic            in_intx,
    input  logic [TYPE_W-1:0] in_typ,
    output logic [VA_W-1:0] rec_from,
    output logic [VA_W-1:0] rec_to,
    output logic            rec_abort,
    output logic            rec_intx,
    output brtype_t         typ_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_from  <= '0;
            rec_to    <= '0;
            rec_abort <= 1'b0;
            rec_intx  <= 1'b0;
            typ_q     <= '0;
        end else begin
            if (cap_rec) begin
                rec_from  <= in_from;
                rec_to    <= in_to;
                rec_abort <= in_abort;
                rec_intx  <= in_intx;
            end
            if (cap_typ) typ_q <= brtype_t'(in_typ);
        end
    end
endmodule

// File: rtl/brf_walker.sv
module brf_walker
    import brf_pkg::*;
#(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TYPE_W-1:0]  sel_in,
    input  logic               dedup_in,
    input  logic [CNT_W-1:0]   count_in,
    input  logic               cls_ack,
    input  logic               keep,
    input  logic [CNT_W-1:0]   slot,
    input  logic [CNT_W-1:0]   wp_next,
    output brtype_t            sel_q,
    output logic               dedup_q,
    output logic               bypass_q,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CNT_W-1:0]   rp_q,
    output logic [CNT_W-1:0]   wp_q,
    output logic               prev_kept,
    output logic               at_first,
    output logic               busy,
    output logic               cap_rec,
    output logic               cap_typ,
    output logic               done,
    output logic [CNT_W-1:0]   count_out,
    output logic               cls_req,
    output logic               mem_rd,
    output logic               mem_we,
    output logic [IDX_W-1:0]   mem_addr
);
    walk_st_t st;
    logic [CNT_W-1:0] rp_inc;

    assign rp_inc = rp_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            sel_q     <= '0;
            dedup_q   <= 1'b0;
            bypass_q  <= 1'b0;
            cnt_q     <= '0;
            rp_q      <= '0;
            wp_q      <= '0;
            prev_kept <= 1'b0;
            count_out <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    sel_q     <= brtype_t'(sel_in);
                    dedup_q   <= dedup_in;
                    bypass_q  <= sel_is_bypass(sel_in);
                    cnt_q     <= count_in;
                    rp_q      <= '0;
                    wp_q      <= '0;
                    prev_kept <= 1'b0;
                    if (count_in == '0) begin
                        count_out <= '0;
                        st        <= ST_DONE;
                    end else begin
                        st <= ST_READ;
                    end
                end
                ST_READ:  st <= ST_LATCH;
                ST_LATCH: st <= bypass_q ? ST_DECIDE : ST_CLASS;
                ST_CLASS: if (cls_ack) st <= ST_DECIDE;
                ST_DECIDE: begin
                    wp_q      <= wp_next;
                    prev_kept <= keep;
                    rp_q      <= rp_inc;
                    if (rp_inc == cnt_q) begin
                        count_out <= wp_next;
                        st        <= ST_DONE;
                    end else begin
                        st <= ST_READ;
                    end
                end
                ST_DONE:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (st != ST_IDLE);
        cap_rec  = (st == ST_LATCH);
        cls_req  = (st == ST_CLASS);
        cap_typ  = (st == ST_CLASS) && cls_ack;
        done     = (st == ST_DONE);
        mem_rd   = (st == ST_READ);
        mem_we   = (st == ST_DECIDE) && keep && (slot != rp_q);
        mem_addr = (st == ST_DECIDE) ? slot[IDX_W-1:0] : rp_q[IDX_W-1:0];
        at_first = (rp_q == '0);
    end
endmodule

// File: rtl/brf_filter_compact.sv
module brf_filter_compact
    import brf_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned VA_W  = 32,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1),
    parameter int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TYPE_W-1:0]  sel_mask,
    input  logic               dedup_en,
    input  logic [CNT_W-1:0]   count_in,
    output logic               done,
    output logic [CNT_W-1:0]   count_out,
    output logic [IDX_W-1:0]   mem_addr,
    output logic               mem_rd,
    input  logic [VA_W-1:0]    mem_rdata_from,
    input  logic [VA_W-1:0]    mem_rdata_to,
    input  logic               mem_rdata_abort,
    input  logic               mem_rdata_intx,
    output logic               mem_we,
    output logic [VA_W-1:0]    mem_wdata_from,
    output logic [VA_W-1:0]    mem_wdata_to,
    output logic               mem_wdata_abort,
    output logic               mem_wdata_intx,
    output logic               cls_req,
    output logic [VA_W-1:0]    cls_from,
    output logic [VA_W-1:0]    cls_to,
    output logic               cls_abort,
    input  logic               cls_ack,
    input  logic [TYPE_W-1:0]  cls_type
);
    brtype_t          sel_q;
    brtype_t          typ_q;
    logic             dedup_q, bypass_q, prev_kept, at_first, busy;
    logic             cap_rec, cap_typ, keep;
    logic [CNT_W-1:0] cnt_q, rp_q, wp_q, slot, wp_next;
    logic [VA_W-1:0]  rec_from, rec_to;
    logic             rec_abort, rec_intx;

    brf_walker #(.CNT_W(CNT_W), .IDX_W(IDX_W)) walk_i (
        .clk(clk), .rst(rst), .start(start), .sel_in(sel_mask),
        .dedup_in(dedup_en), .count_in(count_in), .cls_ack(cls_ack),
        .keep(keep), .slot(slot), .wp_next(wp_next),
        .sel_q(sel_q), .dedup_q(dedup_q), .bypass_q(bypass_q), .cnt_q(cnt_q),
        .rp_q(rp_q), .wp_q(wp_q), .prev_kept(prev_kept), .at_first(at_first),
        .busy(busy), .cap_rec(cap_rec), .cap_typ(cap_typ), .done(done),
        .count_out(count_out), .cls_req(cls_req), .mem_rd(mem_rd),
        .mem_we(mem_we), .mem_addr(mem_addr)
    );

    brf_rec_hold #(.VA_W(VA_W)) hold_i (
        .clk(clk), .rst(rst), .cap_rec(cap_rec), .cap_typ(cap_typ),
        .in_from(mem_rdata_from), .in_to(mem_rdata_to),
        .in_abort(mem_rdata_abort), .in_intx(mem_rdata_intx), .in_typ(cls_type),
        .rec_from(rec_from), .rec_to(rec_to), .rec_abort(rec_abort),
        .rec_intx(rec_intx), .typ_q(typ_q)
    );

    brf_judge #(.CNT_W(CNT_W)) judge_i (
        .sel(sel_q), .typ(typ_q), .rec_intx(rec_intx), .rec_abort(rec_abort),
        .bypass(bypass_q), .dedup(dedup_q), .at_first(at_first),
        .prev_kept(prev_kept), .wp(wp_q), .keep(keep), .slot(slot),
        .wp_next(wp_next)
    );

    assign cls_from        = rec_from;
    assign cls_to          = rec_to;
    assign cls_abort       = rec_abort;
    assign mem_wdata_from  = rec_from;
    assign mem_wdata_to    = rec_to;
    assign mem_wdata_abort = rec_abort;
    assign mem_wdata_intx  = rec_intx;
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
    parameter int unsigned CNT_W = 4,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned VA_W  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             cls_req,
    input logic             cls_ack,
    input logic [VA_W-1:0]  cls_from,
    input logic [VA_W-1:0]  cls_to,
    input logic             mem_we,
    input logic [IDX_W-1:0] mem_addr,
    input logic [CNT_W-1:0] rp_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] count_out,
    input logic [8:0]       sel_q,
    input logic             bypass_q
);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        cls_req && !cls_ack |=> cls_req && $stable(cls_from) && $stable(cls_to));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_bypass_noclass_R1: assert property (@(posedge clk) disable iff (rst)
        busy && bypass_q |-> !cls_req);

    assert_write_behind_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (CNT_W'(mem_addr) < rp_q));

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (count_out <= cnt_q));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(sel_q));
endmodule

bind brf_filter_compact brf_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W), .VA_W(VA_W)) chk_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cls_req(cls_req), .cls_ack(cls_ack), .cls_from(cls_from), .cls_to(cls_to),
    .mem_we(mem_we), .mem_addr(mem_addr), .rp_q(rp_q), .cnt_q(cnt_q),
    .count_out(count_out), .sel_q(sel_q), .bypass_q(bypass_q)
);

// File: tb/brf_filter_compact_tb.sv
module brf_filter_compact_tb_top;
    localparam int N  = 4;
    localparam int VW = 12;
    localparam int CW = 3;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [8:0] sel_mask = '0;
    logic dedup_en = 1'b0;
    logic [CW-1:0] count_in = '0;
    logic done, mem_rd, mem_we, cls_req, cls_abort;
    logic [CW-1:0] count_out;
    logic [IW-1:0] mem_addr;
    logic [VW-1:0] rd_from = '0, rd_to = '0;
    logic rd_ab = 1'b0, rd_tx = 1'b0;
    logic [VW-1:0] wd_from, wd_to, cls_from, cls_to;
    logic wd_ab, wd_tx;
    logic cls_ack = 1'b0;
    logic [8:0] cls_type = '0;

    always #4 clk = ~clk;

    brf_filter_compact #(.DEPTH(N), .VA_W(VW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .sel_mask(sel_mask),
        .dedup_en(dedup_en), .count_in(count_in), .done(done),
        .count_out(count_out), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata_from(rd_from), .mem_rdata_to(rd_to),
        .mem_rdata_abort(rd_ab), .mem_rdata_intx(rd_tx), .mem_we(mem_we),
        .mem_wdata_from(wd_from), .mem_wdata_to(wd_to),
        .mem_wdata_abort(wd_ab), .mem_wdata_intx(wd_tx), .cls_req(cls_req),
        .cls_from(cls_from), .cls_to(cls_to), .cls_abort(cls_abort),
        .cls_ack(cls_ack), .cls_type(cls_type)
    );

    logic [VW-1:0] m_from [N];
    logic [VW-1:0] m_to   [N];
    logic          m_ab   [N];
    logic          m_tx   [N];

    int n_chk = 0, n_fail = 0, wr_cnt = 0, acc_cnt = 0, cls_cnt = 0;
    bit ended = 0;

    // bench classifier: type comes from target bits 8:0, source 0 gives none
    function automatic logic [8:0] bench_type(logic [VW-1:0] f, logic [VW-1:0] t);
        return (f == '0) ? 9'h000 : t[8:0];
    endfunction

    always @(posedge clk) begin
        if (mem_we) begin
            m_from[mem_addr] <= wd_from;
            m_to[mem_addr]   <= wd_to;
            m_ab[mem_addr]   <= wd_ab;
            m_tx[mem_addr]   <= wd_tx;
            wr_cnt = wr_cnt + 1;
        end
        if (mem_rd) begin
            rd_from <= m_from[mem_addr];
            rd_to   <= m_to[mem_addr];
            rd_ab   <= m_ab[mem_addr];
            rd_tx   <= m_tx[mem_addr];
        end
        if (mem_we || mem_rd) acc_cnt = acc_cnt + 1;
        if (cls_req && cls_ack) cls_cnt = cls_cnt + 1;
    end

    int  lat = 0;
    bit  armed = 0;
    always @(negedge clk) begin
        if (cls_ack) cls_ack = 1'b0;
        else if (cls_req) begin
            if (!armed) begin armed = 1; lat = int'(cls_from[1:0]); end
            if (lat == 0) begin
                cls_ack  = 1'b1;
                cls_type = bench_type(cls_from, cls_to);
                armed    = 0;
            end else lat = lat - 1;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit ref_keep(logic [VW-1:0] f, logic [VW-1:0] t, logic tx, logic [8:0] sel);
        logic [8:0] ty;
        ty = bench_type(f, t);
        if (ty != 0 && (sel[7] || sel[8])) ty = ty | (tx ? 9'h080 : 9'h100);
        return (ty != 0) && ((sel & ty) == ty);
    endfunction

    task automatic set_rec(int i, logic [VW-1:0] f, logic [8:0] ty, logic ab, logic tx);
        m_from[i] = f;
        m_to[i]   = {3'b101, ty};
        m_ab[i]   = ab;
        m_tx[i]   = tx;
    endtask

    task automatic run_case(int cnt, logic [8:0] sel, logic ded, bit poke, string tag);
        logic [VW-1:0] of [N];
        logic [VW-1:0] ot [N];
        logic oa [N];
        logic ox [N];
        int lst [N];
        int ex  [N];
        int o = 0, ne = 0, waited = 0;
        bit collapsed = 0, bypass;
        for (int i = 0; i < N; i++) begin
            of[i] = m_from[i]; ot[i] = m_to[i]; oa[i] = m_ab[i]; ox[i] = m_tx[i];
        end
        for (int i = 0; i < cnt; i++) begin
            if (ded && oa[i] && o > 0) begin o--; collapsed = 1; end
            lst[o] = i; o++;
        end
        bypass = ((sel & 9'h07F) == 9'h07F);
        for (int k = 0; k < o; k++)
            if (bypass || ref_keep(of[lst[k]], ot[lst[k]], ox[lst[k]], sel)) begin
                ex[ne] = lst[k]; ne++;
            end
        wr_cnt = 0; acc_cnt = 0; cls_cnt = 0;
        @(negedge clk);
        start = 1'b1; sel_mask = sel; dedup_en = ded; count_in = CW'(cnt);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1'b1; sel_mask = ~sel; dedup_en = ~ded; count_in = CW'(1);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && waited < 400) begin @(negedge clk); waited++; end
        if (!done) begin
            chk(0, {tag, " done timeout"}, waited, 400);
            return;
        end
        chk(count_out == CW'(ne), {tag, " R4 count"}, int'(count_out), ne);
        for (int k = 0; k < ne; k++) begin
            chk(m_from[k] == of[ex[k]] && m_to[k] == ot[ex[k]] &&
                m_ab[k] == oa[ex[k]] && m_tx[k] == ox[ex[k]],
                {tag, " R4 slot"}, int'(m_from[k]), int'(of[ex[k]]));
        end
        if (ne == cnt && !collapsed)
            chk(wr_cnt == 0, {tag, " R5 writes"}, wr_cnt, 0);
        if (bypass)
            chk(cls_cnt == 0, {tag, " R1 classify"}, cls_cnt, 0);
        if (cnt == 0)
            chk(acc_cnt == 0, {tag, " R11 access"}, acc_cnt, 0);
        @(negedge clk);
        chk(!done && count_out == CW'(ne), {tag, " R7 pulse"}, int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !cls_req && !mem_rd && !mem_we && count_out == '0,
            "R10 reset", int'(count_out), 0);

        // R2: in-transaction record, user conditional type
        set_rec(0, 12'h101, 9'h011, 1'b0, 1'b1);
        run_case(1, 9'h091, 1'b0, 0, "R2 tagged-in");
        chk(count_out == 1, "R2 kept", int'(count_out), 1);
        run_case(1, 9'h111, 1'b0, 0, "R2 tagged-out");
        chk(count_out == 0, "R2 dropped", int'(count_out), 0);

        // R3: none type (source 0) and a non-subset type
        set_rec(0, 12'h000, 9'h011, 1'b0, 1'b0);
        set_rec(1, 12'h203, 9'h021, 1'b0, 1'b0);
        set_rec(2, 12'h302, 9'h005, 1'b0, 1'b0);
        run_case(3, 9'h015, 1'b0, 0, "R3 filter");
        chk(count_out == 1, "R3 survivors", int'(count_out), 1);

        // R6: abort at index 1 replaces index 0; abort at index 0 ignored
        set_rec(0, 12'h404, 9'h041, 1'b1, 1'b0);
        set_rec(1, 12'h505, 9'h041, 1'b1, 1'b0);
        set_rec(2, 12'h606, 9'h011, 1'b0, 1'b0);
        set_rec(3, 12'h707, 9'h011, 1'b0, 1'b0);
        run_case(4, 9'h07F, 1'b1, 0, "R6 collapse");
        chk(count_out == 3 && m_from[0] == 12'h505, "R6 reuse",
            int'(m_from[0]), 12'h505);

        // R11: empty run; R1 and R5: full bypass
        run_case(0, 9'h000, 1'b0, 0, "R11 empty");
        run_case(4, 9'h1FF, 1'b0, 0, "R1 bypass");

        // R8: start pulse mid-run
        run_case(4, 9'h03C, 1'b1, 1, "R8 poke");

        for (int r = 0; r < 1200; r++) begin
            int cnt;
            logic [8:0] sel;
            cnt = $urandom_range(0, N);
            for (int i = 0; i < N; i++) begin
                logic [8:0] ty;
                logic [VW-1:0] f;
                ty = ($urandom_range(0, 5) == 0) ? 9'h000 :
                     (9'(1) << $urandom_range(2, 6));
                ty = ty | 9'($urandom_range(1, 2));
                f  = ($urandom_range(0, 6) == 0) ? '0 : VW'($urandom_range(1, 4095));
                set_rec(i, f, ty, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
            case (r % 5)
                0: sel = 9'($urandom);
                1: sel = 9'h07F | (9'($urandom) & 9'h180);
                2: sel = 9'($urandom) & 9'h07F;
                3: sel = 9'h003 | (9'($urandom) & 9'h1FC);
                default: sel = 9'($urandom) | 9'h003;
            endcase
            run_case(cnt, sel, 1'($urandom_range(0, 1)), (cnt >= 2) && (r % 7 == 0),
                     "R2 R3 R4 R6 R8 sweep");
        end

        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule